// File: doc/BRIEF.md
# Vector Memory Lane Gate

This block sits between the per-lane address stage of a SIMD unit and the global memory pipeline. One vector memory instruction arrives at a time. It carries an execute mask and a separately computed out-of-range mask. The block sends the memory system a request whose lane mask contains only lanes that are both active and in range. Out-of-range store lanes are dropped. For loads, the block builds the register writeback: active in-range lanes take the returned data, and active out-of-range lanes take zero. Lanes with a clear execute bit are never written.

The execute mask itself is never narrowed. It travels unchanged to the writeback enables, and the out-of-range mask is held in its own register so that zero-fill can be applied when the data comes back. Sometimes no lane is left to access memory and the instruction is neither a memory synchronization nor an end-of-kernel marker. In that case the instruction finishes in the cycle it is accepted. It pushes one entry into the ordered return queue, hands back one issue credit and, for a load, performs its zero writeback. In-order completion counting downstream therefore stays consistent. One instruction is in flight at a time, and the issue port uses valid/ready.

Top module: `vmem_lane_gate`

## Requirements
- R1: One cycle after an issue handshake that is not self-completed, `req_valid` rises with `req_lanes` bit i equal to execute bit i AND NOT out-of-range bit i. `req_lanes`, `req_tag`, `req_write` and `req_special` hold while `req_ready` is low.
- R2: On every writeback, `wb_we` equals the execute mask exactly as issued. Lanes whose execute bit is 0 have `wb_we` bit 0. When `wb_valid` is 0, `wb_we` is all zero.
- R3: On a load response writeback, lane i of `wb_data` (bits i*DW up to i*DW+DW-1) equals lane i of `rsp_data` when the lane is in range, and is zero when the lane is out of range.
- R4: A store's request has `req_write`=1 and carries no out-of-range lane. A plain load has `req_write`=0, and so do synchronization and end-of-kernel requests.
- R5: The out-of-range mask is replaced at every issue. A lane flagged in one instruction is not zeroed in the next instruction unless it is flagged again.
- R6: If the request mask is all zero and neither `iss_sync` nor `iss_eok` is set, no request is sent. `ret_push` pulses in the handshake cycle with `ret_tag` = `iss_tag`, and the block is ready again in the next cycle.
- R7: Every instruction pushes exactly one `ret_push`, and the tags come out in issue order. A load that reaches memory completes on its `rsp_valid` cycle. A store, synchronization or end-of-kernel instruction completes on its `req_ready` acceptance cycle.
- R8: `credit_ret` pulses for exactly one cycle, in the handshake cycle of a self-completed instruction, and at no other time.
- R9: A synchronization or end-of-kernel instruction with an empty request mask is still sent as a request with `req_special`=1. It is never self-completed.
- R10: `iss_ready` is 1 only when no instruction is in flight. After reset the block is idle with `iss_ready`=1, and `req_valid`, `ret_push`, `credit_ret` and `wb_valid` are all 0. A `rsp_valid` while no load is waiting has no effect.
- R11: A self-completed load writes back in its handshake cycle. `wb_valid`=1, `wb_we` equals the execute mask, and `wb_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Block can accept an instruction |
| iss_load | input | 1 | 1 = load, 0 = store |
| iss_sync | input | 1 | Memory synchronization instruction |
| iss_eok | input | 1 | End-of-kernel marker |
| iss_tag | input | TAGW | Instruction tag |
| iss_exec | input | LANES | Execute mask |
| iss_oob | input | LANES | Out-of-range mask |
| req_valid | output | 1 | Memory request pending |
| req_ready | input | 1 | Memory pipeline accepts the request |
| req_write | output | 1 | Request is a store |
| req_special | output | 1 | Request is a synchronization or end-of-kernel |
| req_tag | output | TAGW | Tag of the request |
| req_lanes | output | LANES | Lanes that access memory |
| rsp_valid | input | 1 | Load data returned |
| rsp_data | input | LANES*DW | Returned lane data |
| wb_valid | output | 1 | Register writeback this cycle |
| wb_we | output | LANES | Per-lane write enables |
| wb_data | output | LANES*DW | Per-lane writeback data |
| ret_push | output | 1 | Push into the ordered return queue |
| ret_tag | output | TAGW | Tag pushed |
| credit_ret | output | 1 | One issue credit returned |

## Verification
The hardest case to reach is self-completion. It needs an instruction in which every active lane is also flagged out of range, and random masks over many lanes almost never produce one. The bench runs with a small lane count. It drives directed instructions with the execute mask fully covered by the out-of-range mask, and instructions with an empty execute mask. Its random phase builds the out-of-range mask as the OR of several random words, so that fully masked instructions show up often, mixed in with random request backpressure and random response timing.

// File: rtl/vmem_lane_gate.sv
module vmem_lane_gate #(
  parameter int LANES = 64,
  parameter int DW    = 32,
  parameter int TAGW  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iss_valid,
  output logic               iss_ready,
  input  logic               iss_load,
  input  logic               iss_sync,
  input  logic               iss_eok,
  input  logic [TAGW-1:0]    iss_tag,
  input  logic [LANES-1:0]   iss_exec,
  input  logic [LANES-1:0]   iss_oob,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic               req_special,
  output logic [TAGW-1:0]    req_tag,
  output logic [LANES-1:0]   req_lanes,
  input  logic               rsp_valid,
  input  logic [LANES*DW-1:0] rsp_data,
  output logic               wb_valid,
  output logic [LANES-1:0]   wb_we,
  output logic [LANES*DW-1:0] wb_data,
  output logic               ret_push,
  output logic [TAGW-1:0]    ret_tag,
  output logic               credit_ret
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t            st;
  logic [LANES-1:0]  exec_q, oob_q;
  logic              load_q, special_q;
  logic [TAGW-1:0]   tag_q;

  logic fire, self_cmp, req_done, rsp_done, needs_data;

  assign iss_ready  = (st == S_IDLE);
  assign fire       = iss_valid & iss_ready;
  assign self_cmp   = fire & ~|(iss_exec & ~iss_oob) & ~(iss_sync | iss_eok);
  assign needs_data = load_q & ~special_q;
  assign req_done   = req_valid & req_ready;
  assign rsp_done   = (st == S_WAIT) & rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      exec_q    <= '0;
      oob_q     <= '0;
      load_q    <= 1'b0;
      special_q <= 1'b0;
      tag_q     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (fire) begin
          exec_q    <= iss_exec;
          oob_q     <= iss_oob;
          load_q    <= iss_load;
          special_q <= iss_sync | iss_eok;
          tag_q     <= iss_tag;
          if (!self_cmp) st <= S_REQ;
        end
        S_REQ:  if (req_ready) st <= needs_data ? S_WAIT : S_IDLE;
        S_WAIT: if (rsp_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_valid   = (st == S_REQ);
  assign req_lanes   = exec_q & ~oob_q;
  assign req_write   = ~load_q & ~special_q;
  assign req_special = special_q;
  assign req_tag     = tag_q;

  assign ret_push   = self_cmp | (req_done & ~needs_data) | rsp_done;
  assign ret_tag    = self_cmp ? iss_tag : tag_q;
  assign credit_ret = self_cmp;

  assign wb_valid = (self_cmp & iss_load) | rsp_done;
  assign wb_we    = !wb_valid ? '0 : (self_cmp ? iss_exec : exec_q);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wb_data[l*DW +: DW] = (rsp_done & ~oob_q[l]) ? rsp_data[l*DW +: DW] : '0;
  end

endmodule

module vmem_lane_gate_chk #(
  parameter int LANES = 64,
  parameter int TAGW  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             iss_sync,
  input logic             iss_eok,
  input logic [TAGW-1:0]  iss_tag,
  input logic [LANES-1:0] iss_exec,
  input logic [LANES-1:0] iss_oob,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_special,
  input logic [TAGW-1:0]  req_tag,
  input logic [LANES-1:0] req_lanes,
  input logic             ret_push,
  input logic [TAGW-1:0]  ret_tag,
  input logic             credit_ret
);
  logic hs, empty_plain;
  assign hs          = iss_valid && iss_ready;
  assign empty_plain = ((iss_exec & ~iss_oob) == '0) && !iss_sync && !iss_eok;

  // R1
  req_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && !empty_plain) |=> (req_valid && req_lanes == $past(iss_exec & ~iss_oob)));

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_lanes) && $stable(req_tag)));

  // R6
  self_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && empty_plain) |-> (ret_push && ret_tag == iss_tag && credit_ret));

  // R8
  credit_only_chk: assert property (@(posedge clk) disable iff (rst)
    credit_ret |-> (hs && ret_push && !req_valid));

  // R9
  special_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && (iss_sync || iss_eok)) |=> (req_valid && req_special));

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !iss_ready);
endmodule

bind vmem_lane_gate vmem_lane_gate_chk #(.LANES(LANES), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_sync(iss_sync), .iss_eok(iss_eok), .iss_tag(iss_tag),
  .iss_exec(iss_exec), .iss_oob(iss_oob), .req_valid(req_valid),
  .req_ready(req_ready), .req_special(req_special), .req_tag(req_tag),
  .req_lanes(req_lanes), .ret_push(ret_push), .ret_tag(ret_tag),
  .credit_ret(credit_ret)
);

// File: tb/vmem_lane_gate_tb.sv
module vmem_lane_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int DW    = 8;
  localparam int TAGW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0, iss_load = 1'b0, iss_sync = 1'b0, iss_eok = 1'b0;
  logic [TAGW-1:0] iss_tag = '0;
  logic [LANES-1:0] iss_exec = '0, iss_oob = '0;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [LANES*DW-1:0] rsp_data = '0;
  logic iss_ready, req_valid, req_write, req_special, wb_valid, ret_push, credit_ret;
  logic [TAGW-1:0] req_tag, ret_tag;
  logic [LANES-1:0] req_lanes, wb_we;
  logic [LANES*DW-1:0] wb_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmem_lane_gate #(.LANES(LANES), .DW(DW), .TAGW(TAGW)) u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_load(iss_load), .iss_sync(iss_sync), .iss_eok(iss_eok), .iss_tag(iss_tag),
    .iss_exec(iss_exec), .iss_oob(iss_oob), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_special(req_special), .req_tag(req_tag),
    .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_we(wb_we), .wb_data(wb_data), .ret_push(ret_push),
    .ret_tag(ret_tag), .credit_ret(credit_ret));

  int checks = 0, errors = 0, cycles = 0;
  bit armed = 0;
  bit rand_rsp = 1;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", r, cycles, act, exp);
    end
  endtask

  // reference model state: 0 idle, 1 request pending, 2 awaiting load data
  int m_st = 0;
  bit [LANES-1:0] m_exec, m_oob, m_lanes;
  bit m_load, m_spec;
  bit [TAGW-1:0] m_tag, next_ret = 0;

  function automatic bit [LANES-1:0] live_lanes(bit [LANES-1:0] ex, bit [LANES-1:0] ob);
    bit [LANES-1:0] r = '0;
    for (int i = 0; i < LANES; i++) if (ex[i] && !ob[i]) r[i] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) m_st = 0;
    else if (m_st == 0) begin
      if (iss_valid) begin
        m_exec = iss_exec; m_oob = iss_oob; m_load = iss_load;
        m_spec = iss_sync || iss_eok; m_tag = iss_tag;
        m_lanes = live_lanes(iss_exec, iss_oob);
        if (m_lanes != 0 || m_spec) m_st = 1;
      end
    end else if (m_st == 1) begin
      if (req_ready) m_st = (m_load && !m_spec) ? 2 : 0;
    end else if (rsp_valid) m_st = 0;
  end

  always begin
    @(negedge clk);
    #2;
    if (armed) begin
      bit e_self, e_ret, e_wbv, resp;
      bit [LANES-1:0] e_we;
      bit [LANES*DW-1:0] e_data;
      e_self = (m_st == 0) && iss_valid && live_lanes(iss_exec, iss_oob) == 0 && !iss_sync && !iss_eok;
      resp   = (m_st == 2) && rsp_valid;
      e_ret  = e_self || ((m_st == 1) && req_ready && !(m_load && !m_spec)) || resp;
      e_wbv  = (e_self && iss_load) || resp;
      e_we   = !e_wbv ? '0 : (e_self ? iss_exec : m_exec);
      e_data = '0;
      if (resp) for (int i = 0; i < LANES; i++)
        if (!m_oob[i]) e_data[i*DW +: DW] = rsp_data[i*DW +: DW];
      chk("R10 iss_ready", iss_ready, m_st == 0);
      chk("R1 req_valid", req_valid, m_st == 1);
      if (m_st == 1) begin
        chk("R1 req_lanes", req_lanes, m_lanes);
        chk("R4 req_write", req_write, !m_load && !m_spec);
        chk("R9 req_special", req_special, m_spec);
        chk("R1 req_tag", req_tag, m_tag);
      end
      chk("R6 R7 ret_push", ret_push, e_ret);
      if (e_ret && ret_push) begin
        chk("R7 ret_tag order", ret_tag, next_ret);
        next_ret = next_ret + 1'b1;
      end
      chk("R8 credit_ret", credit_ret, e_self);
      chk("R11 wb_valid", wb_valid, e_wbv);
      chk("R2 wb_we", wb_we, e_we);
      if (e_wbv) chk("R3 R5 R11 wb_data", wb_data, e_data);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rand_rsp) begin
        req_ready = ($urandom % 3) != 0;
        rsp_valid = ($urandom % 2) != 0;
        rsp_data  = {$urandom, $urandom};
      end
    end
  end

  bit [TAGW-1:0] tag_ctr = 0;

  task automatic issue(input bit ld, input bit sy, input bit ek,
                       input bit [LANES-1:0] ex, input bit [LANES-1:0] ob);
    bit ok;
    @(negedge clk);
    iss_valid = 1; iss_load = ld; iss_sync = sy; iss_eok = ek;
    iss_exec = ex; iss_oob = ob; iss_tag = tag_ctr;
    ok = 0;
    while (!ok) begin
      #1 ok = iss_ready;
      @(negedge clk);
    end
    iss_valid = 0; iss_exec = $urandom; iss_oob = $urandom;
    tag_ctr = tag_ctr + 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #2;
    chk("R10 reset ready", iss_ready, 1);
    chk("R10 reset req_valid", req_valid, 0);
    chk("R10 reset ret_push", ret_push, 0);
    chk("R10 reset wb_valid", wb_valid, 0);
    rsp_valid = 1;
    @(negedge clk); #2;
    chk("R10 stray response ignored", {wb_valid, ret_push}, 0);
    armed = 1;
    issue(1, 0, 0, 8'hFF, 8'h0F);  // R3 mixed load
    issue(1, 0, 0, 8'hF0, 8'hF0);  // R11 all active lanes out of range
    issue(1, 0, 0, 8'hFF, 8'h00);  // R5 previous flags cleared
    issue(0, 0, 0, 8'h3C, 8'h24);  // R4 store drops flagged lanes
    issue(0, 0, 0, 8'h81, 8'hFF);  // R6 store self-complete
    issue(1, 0, 0, 8'h00, 8'h00);  // R6 empty execute mask
    issue(1, 0, 0, 8'h00, 8'h00);  // back-to-back self-complete
    issue(0, 1, 0, 8'h00, 8'h00);  // R9 sync with empty mask
    issue(1, 0, 1, 8'h0F, 8'h0F);  // R9 end-of-kernel, all out of range
    issue(1, 0, 0, 8'hA5, 8'h5A);  // R2 partial execute
    for (int n = 0; n < 400; n++) begin
      bit [LANES-1:0] ob;
      ob = 8'($urandom) | 8'($urandom) | ((n % 3 == 0) ? 8'hFF : 8'h00);
      issue(($urandom % 2) != 0, ($urandom % 17) == 0, ($urandom % 23) == 0,
            8'($urandom), ob);
    end
    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule